// File: doc/BRIEF.md
# Word Write-Protection Checker with Counting-Filter Spill

This block decides, for every store, whether the target word is write-protected. Protected words are registered one at a time with an insert command and withdrawn with a remove command. Each registered word is kept as a full word-address tag in a small set-associative array. The set is chosen by XOR-folding the word address.

A set can fill up. Once all of its tag ways are in use, the set is marked as spilled. Any further words for that set go into a per-set counting filter, which is built from the storage that the other half of the ways would have used. A store lookup returns one of three answers:

- **fault**: the word is certainly protected.
- **pass**: the word is certainly not protected.
- **memory check**: the filter cannot rule the word out, so the caller must consult the full protection vector held in memory. That vector is outside this block.

Because the filter counts rather than just marking, a spilled word can be removed without any memory access.

Top module: `wpc_top`

## Requirements
- R1: After reset no word is protected: a lookup of any address returns pass (code 2'b00).
- R2: The set index is the XOR of all SET_W-bit sections of the word address op_addr[31:2], with sections aligned starting at bit 2. Words whose sections fold to the same value compete for the same ways.
- R3: A lookup whose word address matches a stored tag returns fault (code 2'b01). Address bits [1:0] are ignored, so every byte of a protected word faults.
- R4: Inserting a word that already matches a tag changes nothing. In particular it does not take a second way.
- R5: Inserting a word into a set that has a free tag way stores it there. A later lookup of that word returns fault.
- R6: Inserting a new word into a set whose WAYS/2 tag ways are all valid marks the set as spilled and adds the word to the set's filter. A later lookup of that word returns memory check (code 2'b10).
- R7: The filter uses HASHES slot indices out of SLOTS counters per set. Index k is formed in three steps. First, rotate the 30-bit word address left by 5k+3. Second, XOR the result down to a SLOT_W-bit value, where bit j is the XOR of all bits whose position mod SLOT_W equals j. Third, subtract SLOTS if the result is at or above SLOTS. In a spilled set, a tag miss for which any of these counters is zero returns pass. A tag miss for which all of them are non-zero returns memory check.
- R8: In a set that is not spilled, any tag miss returns pass.
- R9: Removing a word that matches a tag frees that way. The word then looks up as pass if the set's filter does not hold it, and a later insert may reuse the way.
- R10: Removing a word that is absent from the tags of a spilled set decrements each of its filter counters once; a counter at its maximum stays there. Other filter words keep answering memory check. When every counter of the set reaches zero, the spilled mark is cleared.
- R11: res_valid is high for exactly one cycle, the cycle after a lookup is accepted. Inserts and removes produce no result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | A command is presented this cycle |
| op_kind | input | 2 | 0 lookup, 1 insert protection, 2 remove protection, 3 no operation |
| op_addr | input | ADDR_W | Byte address of the store or of the word to protect |
| res_valid | output | 1 | Lookup result valid |
| res_code | output | 2 | 0 pass, 1 fault, 2 memory check |

## Verification
The bench builds the block with its defaults:

| Parameter | Value |
|-----------|-------|
| ADDR_W | 32 |
| SET_W | 2 (four sets) |
| WAYS | 16 (eight tag ways per set) |
| SLOTS | 120 |
| HASHES | 6 |
| CNT_W | 2 |

With eight tag ways, a set can be filled and pushed into spill with only nine inserts. The bench derives its addresses from its own set-index and slot computations. It can therefore pick a spilled word whose slots are covered, and a candidate whose slots are not, so the pass, fault and memory-check outcomes can each be forced on purpose. Two-bit counters hold the two overlapping filter words used in the removal test without saturating.

// File: rtl/wpc_pkg.sv
// Shared encodings for the word protection checker.
// Assumes op_kind and res_code are two bits wide at the ports.
package wpc_pkg;
    typedef enum logic [1:0] {
        OP_LOOKUP = 2'd0,
        OP_INSERT = 2'd1,
        OP_REMOVE = 2'd2,
        OP_NONE   = 2'd3
    } wpc_op_e;

    typedef enum logic [1:0] {
        RES_PASS   = 2'd0,
        RES_FAULT  = 2'd1,
        RES_MEMCHK = 2'd2
    } wpc_res_e;
endpackage

// File: rtl/wpc_set_index.sv
// Folds a word address into a set index by XORing all SET_W-bit sections.
// Assumes WORD_W >= SET_W; a short top section is zero-extended.
module wpc_set_index #(
    parameter int WORD_W = 30,
    parameter int SET_W  = 2
) (
    input  logic [WORD_W-1:0] word,
    output logic [SET_W-1:0]  idx
);
    // Bit i of the word lands in index bit i mod SET_W.
    always_comb begin
        idx = '0;
        for (int i = 0; i < WORD_W; i++) begin
            idx[i % SET_W] = idx[i % SET_W] ^ word[i];
        end
    end
endmodule

// File: rtl/wpc_hash_gen.sv
// Produces HASHES filter slot indices from a word address.
// Each index is a rotate-left by 5k+3, a fold to SLOT_W bits, and a single
// subtraction of SLOTS. Assumes SLOTS > 2**(SLOT_W-1), so one subtraction
// is enough.
module wpc_hash_gen #(
    parameter int WORD_W = 30,
    parameter int SLOTS  = 120,
    parameter int HASHES = 6,
    localparam int SLOT_W = $clog2(SLOTS)
) (
    input  logic [WORD_W-1:0]              word,
    output logic [HASHES-1:0][SLOT_W-1:0]  slot
);
    for (genvar k = 0; k < HASHES; k++) begin : g_hash
        localparam int ROT = (5 * k + 3) % WORD_W;
        logic [WORD_W-1:0] rot;
        logic [SLOT_W-1:0] fold;

        // Rotate the word address, then fold it down to a slot number.
        always_comb begin
            fold = '0;
            for (int i = 0; i < WORD_W; i++) begin
                rot[i] = word[(i - ROT + WORD_W) % WORD_W];
            end
            for (int i = 0; i < WORD_W; i++) begin
                fold[i % SLOT_W] = fold[i % SLOT_W] ^ rot[i];
            end
            slot[k] = (fold >= SLOT_W'(SLOTS)) ? fold - SLOT_W'(SLOTS) : fold;
        end
    end
endmodule

// File: rtl/wpc_filter_bank.sv
// Per-set counting filters: SLOTS saturating counters for each set.
// Increment or decrement touches each distinct selected slot once.
// A saturated counter is never decremented, so the filter never forgets a
// word. Assumes callers remove only words they previously inserted.
module wpc_filter_bank #(
    parameter int SETS   = 4,
    parameter int SET_W  = 2,
    parameter int SLOTS  = 120,
    parameter int HASHES = 6,
    parameter int CNT_W  = 2,
    localparam int SLOT_W = $clog2(SLOTS)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [SET_W-1:0]               set_idx,
    input  logic [HASHES-1:0][SLOT_W-1:0]  slot,
    input  logic                           inc,
    input  logic                           dec,
    output logic                           all_hit,
    output logic                           zero_after
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q [SETS][SLOTS];
    logic [SLOTS-1:0] sel;

    // Mark which slots the current word selects.
    always_comb begin
        sel = '0;
        for (int j = 0; j < SLOTS; j++) begin
            for (int k = 0; k < HASHES; k++) begin
                if (slot[k] == SLOT_W'(j)) sel[j] = 1'b1;
            end
        end
    end

    // The filter hits only when every selected counter is non-zero.
    always_comb begin
        all_hit = 1'b1;
        for (int k = 0; k < HASHES; k++) begin
            if (cnt_q[set_idx][slot[k]] == '0) all_hit = 1'b0;
        end
    end

    // Predict whether the whole set is empty after this cycle's decrement.
    always_comb begin
        logic [CNT_W-1:0] nxt;
        zero_after = 1'b1;
        for (int j = 0; j < SLOTS; j++) begin
            nxt = cnt_q[set_idx][j];
            if (dec && sel[j] && nxt != '0 && nxt != CNT_MAX) nxt = nxt - 1'b1;
            if (nxt != '0) zero_after = 1'b0;
        end
    end

    // Counter update for the addressed set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++)
                for (int j = 0; j < SLOTS; j++)
                    cnt_q[s][j] <= '0;
        end else begin
            for (int j = 0; j < SLOTS; j++) begin
                if (sel[j] && inc && cnt_q[set_idx][j] != CNT_MAX)
                    cnt_q[set_idx][j] <= cnt_q[set_idx][j] + 1'b1;
                else if (sel[j] && dec && cnt_q[set_idx][j] != '0 &&
                         cnt_q[set_idx][j] != CNT_MAX)
                    cnt_q[set_idx][j] <= cnt_q[set_idx][j] - 1'b1;
            end
        end
    end
endmodule

// File: rtl/wpc_top.sv
// Word write-protection checker. A set-associative tag array of protected
// word addresses uses WAYS/2 tag ways per set; the other half of each set's
// storage is a counting filter that takes words once the set is full.
// Every command completes in one cycle, and a lookup result appears one
// cycle later. Assumes at most one command per cycle.
module wpc_top #(
    parameter int ADDR_W = 32,
    parameter int SET_W  = 2,
    parameter int WAYS   = 16,
    parameter int SLOTS  = 120,
    parameter int HASHES = 6,
    parameter int CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [1:0]        op_kind,
    input  logic [ADDR_W-1:0] op_addr,
    output logic              res_valid,
    output logic [1:0]        res_code
);
    import wpc_pkg::*;

    localparam int WORD_W   = ADDR_W - 2;
    localparam int SETS     = 1 << SET_W;
    localparam int TAG_WAYS = WAYS / 2;
    localparam int WAY_W    = (TAG_WAYS > 1) ? $clog2(TAG_WAYS) : 1;
    localparam int SLOT_W   = $clog2(SLOTS);

    logic [WORD_W-1:0]             word;
    logic [1:0]                    unused_byte;
    logic [SET_W-1:0]              set_idx;
    logic [HASHES-1:0][SLOT_W-1:0] slot;
    logic [WORD_W-1:0]             tag_q [SETS][TAG_WAYS];
    logic [TAG_WAYS-1:0]           vld_q [SETS];
    logic [SETS-1:0]               ovf_q;
    logic [TAG_WAYS-1:0]           hit_vec;
    logic                          hit_any, free_any;
    logic [WAY_W-1:0]              free_way;
    logic                          do_lookup, do_insert, do_remove;
    logic                          flt_inc, flt_dec, all_hit, zero_after;

    assign word        = op_addr[ADDR_W-1:2];
    assign unused_byte = op_addr[1:0];

    wpc_set_index #(.WORD_W(WORD_W), .SET_W(SET_W)) u_index (
        .word(word), .idx(set_idx)
    );

    wpc_hash_gen #(.WORD_W(WORD_W), .SLOTS(SLOTS), .HASHES(HASHES)) u_hash (
        .word(word), .slot(slot)
    );

    // Tag compare for every way of the addressed set.
    for (genvar w = 0; w < TAG_WAYS; w++) begin : g_cmp
        assign hit_vec[w] = vld_q[set_idx][w] && (tag_q[set_idx][w] == word);
    end
    assign hit_any = |hit_vec;

    // Pick the lowest-numbered free way of the addressed set.
    always_comb begin
        free_any = 1'b0;
        free_way = '0;
        for (int w = TAG_WAYS - 1; w >= 0; w--) begin
            if (!vld_q[set_idx][w]) begin
                free_any = 1'b1;
                free_way = WAY_W'(w);
            end
        end
    end

    // Command decode and filter steering.
    assign do_lookup = op_valid && (op_kind == OP_LOOKUP);
    assign do_insert = op_valid && (op_kind == OP_INSERT);
    assign do_remove = op_valid && (op_kind == OP_REMOVE);
    assign flt_inc   = do_insert && !hit_any && !free_any;
    assign flt_dec   = do_remove && !hit_any && ovf_q[set_idx];

    wpc_filter_bank #(
        .SETS(SETS), .SET_W(SET_W), .SLOTS(SLOTS), .HASHES(HASHES), .CNT_W(CNT_W)
    ) u_filter (
        .clk(clk), .rst_n(rst_n), .set_idx(set_idx), .slot(slot),
        .inc(flt_inc), .dec(flt_dec), .all_hit(all_hit), .zero_after(zero_after)
    );

    // Tag storage: written on insert into a free way; no reset needed.
    always_ff @(posedge clk) begin
        if (do_insert && !hit_any && free_any)
            tag_q[set_idx][free_way] <= word;
    end

    // Valid bits, spill marks and the registered lookup result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
            ovf_q     <= '0;
            res_valid <= 1'b0;
            res_code  <= RES_PASS;
        end else begin
            if (do_insert && !hit_any && free_any)
                vld_q[set_idx][free_way] <= 1'b1;
            if (do_remove && hit_any)
                vld_q[set_idx] <= vld_q[set_idx] & ~hit_vec;
            if (flt_inc)
                ovf_q[set_idx] <= 1'b1;
            else if (flt_dec && zero_after)
                ovf_q[set_idx] <= 1'b0;
            res_valid <= do_lookup;
            if (do_lookup) begin
                if (hit_any)                      res_code <= RES_FAULT;
                else if (ovf_q[set_idx] && all_hit) res_code <= RES_MEMCHK;
                else                              res_code <= RES_PASS;
            end
        end
    end
endmodule

// File: rtl/wpc_checker.sv
// Temporal checks on the protection checker, attached by bind.
// Observes the ports and the spill marks plus the tag-match results.
module wpc_checker #(
    parameter int SETS  = 4,
    parameter int SET_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             op_valid,
    input logic [1:0]       op_kind,
    input logic             hit_any,
    input logic             free_any,
    input logic             zero_after,
    input logic [SET_W-1:0] set_idx,
    input logic [SETS-1:0]  ovf_q,
    input logic             res_valid,
    input logic [1:0]       res_code
);
    AST_RESULT_ONLY_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == 2'd0) |=> res_valid); // R11
    AST_NO_RESULT_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_valid && op_kind == 2'd0) |=> !res_valid); // R11
    AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> res_code != 2'd3); // R3
    AST_FAULT_ON_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == 2'd0 && hit_any) |=> res_code == 2'd1); // R3
    AST_PASS_UNSPILLED: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == 2'd0 && !hit_any && !ovf_q[set_idx])
        |=> res_code == 2'd0); // R8
    AST_SPILL_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == 2'd1 && !hit_any && !free_any)
        |=> ovf_q[$past(set_idx)]); // R6
    AST_SPILL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == 2'd2 && !hit_any && ovf_q[set_idx] && zero_after)
        |=> !ovf_q[$past(set_idx)]); // R10
endmodule

bind wpc_top wpc_checker #(.SETS(SETS), .SET_W(SET_W)) u_wpc_checker (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
    .hit_any(hit_any), .free_any(free_any), .zero_after(zero_after),
    .set_idx(set_idx), .ovf_q(ovf_q), .res_valid(res_valid), .res_code(res_code)
);

// File: tb/test_wpc_top.sv
// Directed bench for wpc_top with default parameters.
module test_wpc_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] K_LOOK = 2'd0, K_INS = 2'd1, K_REM = 2'd2;
    localparam logic [1:0] C_PASS = 2'd0, C_FAULT = 2'd1, C_MEM = 2'd2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [1:0]  op_kind = 2'd0;
    logic [31:0] op_addr = '0;
    logic        res_valid;
    logic [1:0]  res_code;
    int          n_checks = 0;
    int          n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    wpc_top i_wpc_top (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
        .op_addr(op_addr), .res_valid(res_valid), .res_code(res_code)
    );

    // Set index: XOR of the 2-bit chunks of the word address (R2).
    function automatic logic [1:0] b_set(logic [29:0] w);
        logic [1:0] s = '0;
        for (int c = 0; c < 15; c++) s = s ^ 2'((w >> (2 * c)) & 30'h3);
        return s;
    endfunction

    // Filter slot k as stated in R7.
    function automatic logic [6:0] b_slot(logic [29:0] w, int k);
        logic [59:0] dd;
        logic [29:0] x;
        logic [6:0]  f;
        dd = {w, w};
        x  = 30'(dd >> (30 - (5 * k + 3)));
        f  = '0;
        for (int c = 0; c < 5; c++) f = f ^ 7'((x >> (7 * c)) & 30'h7f);
        if (f >= 7'd120) f = f - 7'd120;
        return f;
    endfunction

    // True when every slot of word b is also a slot of word a.
    function automatic bit b_covered(logic [29:0] a, logic [29:0] b);
        bit all_in = 1'b1;
        for (int i = 0; i < 6; i++) begin
            bit found = 1'b0;
            for (int j = 0; j < 6; j++) if (b_slot(b, i) == b_slot(a, j)) found = 1'b1;
            if (!found) all_in = 1'b0;
        end
        return all_in;
    endfunction

    // The n-th word (from 0) whose set index is s.
    function automatic logic [29:0] b_word(logic [1:0] s, int n);
        int seen = 0;
        for (int w = 1; w < 100000; w++) begin
            if (b_set(30'(w)) == s) begin
                if (seen == n) return 30'(w);
                seen++;
            end
        end
        return '0;
    endfunction

    task automatic do_op(logic [1:0] kind, logic [31:0] addr);
        @(negedge clk);
        op_valid = 1'b1;
        op_kind  = kind;
        op_addr  = addr;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic expect_code(string req, logic [1:0] exp);
        n_checks++;
        if (!res_valid || res_code !== exp) begin
            n_fail++;
            $display("FAIL %s: valid=%0b code=%0d expected valid=1 code=%0d",
                     req, res_valid, res_code, exp);
        end
    endtask

    task automatic look(string req, logic [29:0] w, logic [1:0] bofs, logic [1:0] exp);
        do_op(K_LOOK, {w, bofs});
        expect_code(req, exp);
    endtask

    task automatic t_reset;
        look("R1", b_word(2'd0, 0), 2'd0, C_PASS);
        look("R1", b_word(2'd3, 5), 2'd2, C_PASS);
        do_op(K_INS, {b_word(2'd1, 0), 2'b00});
        n_checks++;
        if (res_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R11: res_valid=%0b after insert expected 0", res_valid);
        end
        do_op(K_REM, {b_word(2'd1, 0), 2'b00});
    endtask

    task automatic t_tags;
        do_op(K_INS, {b_word(2'd0, 0), 2'b00});
        look("R5", b_word(2'd0, 0), 2'd0, C_FAULT);
        look("R3", b_word(2'd0, 0), 2'd3, C_FAULT);
        look("R8", b_word(2'd0, 1), 2'd0, C_PASS);
        do_op(K_INS, {b_word(2'd0, 0), 2'b01});
        for (int n = 1; n < 8; n++) do_op(K_INS, {b_word(2'd0, n), 2'b00});
        look("R4", b_word(2'd0, 7), 2'd0, C_FAULT);
        do_op(K_INS, {b_word(2'd1, 1), 2'b00});
        look("R2", b_word(2'd1, 1), 2'd0, C_FAULT);
    endtask

    task automatic t_spill;
        logic [29:0] a = b_word(2'd0, 8);
        do_op(K_INS, {a, 2'b00});
        look("R6", a, 2'd0, C_MEM);
        look("R2", b_word(2'd0, 3), 2'd0, C_FAULT);
        for (int n = 20; n < 400; n++) begin
            if (!b_covered(a, b_word(2'd0, n))) begin
                look("R7", b_word(2'd0, n), 2'd0, C_PASS);
                break;
            end
        end
    endtask

    task automatic t_counting;
        logic [29:0] a = b_word(2'd0, 8);
        logic [29:0] b = b_word(2'd0, 9);
        do_op(K_INS, {b, 2'b00});
        look("R6", b, 2'd0, C_MEM);
        do_op(K_REM, {a, 2'b00});
        look("R10", b, 2'd0, C_MEM);
        look("R10", a, 2'd0, b_covered(b, a) ? C_MEM : C_PASS);
        do_op(K_REM, {b, 2'b00});
        look("R10", b, 2'd0, C_PASS);
        look("R10", a, 2'd0, C_PASS);
    endtask

    task automatic t_remove_tag;
        do_op(K_REM, {b_word(2'd0, 0), 2'b10});
        look("R9", b_word(2'd0, 0), 2'd0, C_PASS);
        do_op(K_INS, {b_word(2'd0, 10), 2'b00});
        look("R9", b_word(2'd0, 10), 2'd0, C_FAULT);
        do_op(K_INS, {b_word(2'd0, 11), 2'b00});
        look("R6", b_word(2'd0, 11), 2'd0, C_MEM);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        n_checks++;
        if (res_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: res_valid=%0b after reset expected 0", res_valid);
        end
        t_reset();
        t_tags();
        t_spill();
        t_counting();
        t_remove_tag();
        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule